// File: doc/BRIEF.md
# Bus Cycle Wait-State and Ready Sequencer

This block steps one bus cycle through its base states and any inserted wait states. When the cycle-start strobe arrives while the sequencer is idle, it captures the timing configuration of the select that matched the access. That configuration is a wait code, a flag that marks the code as the wide 3-bit form, a bit that says whether external ready is required, and a flag for accesses to the internal control block. The sequencer then walks IDLE → T1 → T2 → T3 → (TW …) → T4 → IDLE.

External ready can come from two inputs. One is asynchronous and passes through a two-flop synchronizer. The other is synchronous and is used as it arrives. The effective ready is the OR of the two. Programmed wait states always run to completion. Ready is examined once, one clock before the last programmed wait (in T3 when there are zero or one programmed waits). If ready is missing at that point, the cycle stretches until ready is seen, and then adds exactly one trailing wait before T4.

The state encoding is IDLE=0, T1=1, T2=2, T3=3, TW=4, T4=5. The named transitions are:

| From | To | Condition |
|------|----|-----------|
| IDLE | T1 | start |
| T1 | T2 | always |
| T2 | T3 | always |
| T3 | T4 | zero waits, ready ok |
| T3 | TW | otherwise |
| TW | TW | count down, or stall while ready is missing |
| TW | T4 | last wait done |
| T4 | IDLE | always |

Top module: `bus_wait_seq`

## Requirements
- R1: After reset, `bus_state` is 0 (IDLE) and `cyc_done` is low.
- R2: A `cyc_start` high while idle gives T1 (1) on the next clock, then T2 (2), then T3 (3), then zero or more TW (4), then T4 (5) for one clock, then IDLE (0).
- R3: With `ws_wide`=0, the wait count equals `ws_code[1:0]` (0..3), and `ws_code[2]` has no effect.
- R4: With `ws_wide`=1, codes 0..3 give 0..3 waits, and codes 4, 5, 6, 7 give 5, 7, 9, 15 waits.
- R5: With `rdy_need`=0, a cycle with N waits lasts 4+N clocks from T1 to T4 inclusive, whatever the ready inputs do.
- R6: With `pcb_hit`=1, the cycle has zero waits and ignores ready, so it lasts 4 clocks.
- R7: With ready required, ready is examined in clock N+2 of the cycle (T1 = clock 1), or in clock 3 when N ≤ 1. If ready is seen there, the cycle lasts 4+N clocks.
- R8: If ready is missing at that point and is first seen in a later clock r, one more wait follows and T4 falls in clock r+2.
- R9: Effective ready is `srdy_in` as sampled at the clock edge, OR `ardy_in` delayed through two flops. An `ardy_in` change made during clock j takes effect for the edge that ends clock j+2.
- R10: `cyc_done` is high exactly in the T4 clock and low in every other state.
- R11: The configuration inputs are captured at start. Later changes to them, and `cyc_start` pulses during a cycle, have no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | Cycle-start strobe, taken only when idle |
| ws_code | input | 3 | Wait code of the matched select |
| ws_wide | input | 1 | 1: code is the wide 3-bit form |
| rdy_need | input | 1 | 1: external ready is required |
| pcb_hit | input | 1 | 1: access targets the internal control block |
| ardy_in | input | 1 | Asynchronous ready |
| srdy_in | input | 1 | Synchronous ready |
| bus_state | output | 3 | Current bus state encoding |
| cyc_done | output | 1 | High for the T4 clock |

## Verification
On every cycle, the assertions check the fixed part of the walk: start to T1, T1 to T2 to T3, the last wait to T4, and T4 to IDLE. They also check that a zero-wait cycle without required ready leaves T3 straight for T4, and that the synchronizer delays ardy by two clocks. Only the bench's scenarios show that cycle lengths follow the decoded wait counts and the early sampling point. The same applies to the single trailing wait after late ready, to ardy and srdy being equivalent apart from latency, and to the configuration being captured at start.

// File: rtl/bus_wait_pkg.sv
package bus_wait_pkg;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } bus_st_e;
endpackage

// File: rtl/rdy_sync.sv
module rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

    // Warm-up counter so the delay check never looks before reset.
    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_chk
            assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (warm >= 2'd2) |-> (sync_out == $past(async_in, 2)));
        end
    endgenerate
endmodule

// File: rtl/wait_decode.sv
module wait_decode
    import bus_wait_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              wide,
    input  logic              pcb,
    output logic [CNT_W-1:0]  nwait
);
    always_comb begin
        if (pcb) begin
            nwait = '0;
        end else if (!wide) begin
            nwait = CNT_W'(code[1:0]);
        end else begin
            unique case (code)
                3'd4:    nwait = CNT_W'(5);
                3'd5:    nwait = CNT_W'(7);
                3'd6:    nwait = CNT_W'(9);
                3'd7:    nwait = CNT_W'(15);
                default: nwait = CNT_W'(code[1:0]);
            endcase
        end
    end
endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq
    import bus_wait_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [CODE_W-1:0] ws_code,
    input  logic              ws_wide,
    input  logic              rdy_need,
    input  logic              pcb_hit,
    input  logic              ardy_in,
    input  logic              srdy_in,
    output logic [2:0]        bus_state,
    output logic              cyc_done
);
    bus_st_e          st, st_nx;
    logic [CNT_W-1:0] nwait_q, nwait_d, dec_wait;
    logic [CNT_W-1:0] wleft, wleft_nx;
    logic             need_q, need_d;
    logic             ardy_s, rdy_ok;

    rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ardy_in),
        .sync_out (ardy_s)
    );

    wait_decode u_dec (
        .code  (ws_code),
        .wide  (ws_wide),
        .pcb   (pcb_hit),
        .nwait (dec_wait)
    );

    assign rdy_ok = !need_q || srdy_in || ardy_s;

    // Next state and wait counter
    always_comb begin
        st_nx    = st;
        wleft_nx = wleft;
        nwait_d  = nwait_q;
        need_d   = need_q;
        unique case (st)
            ST_IDLE: if (cyc_start) begin
                st_nx   = ST_T1;
                nwait_d = dec_wait;
                need_d  = rdy_need && !pcb_hit;
            end
            ST_T1: st_nx = ST_T2;
            ST_T2: st_nx = ST_T3;
            ST_T3: begin
                if (nwait_q >= CNT_W'(2)) begin
                    st_nx    = ST_TW;
                    wleft_nx = nwait_q;
                end else if (!rdy_ok) begin
                    st_nx    = ST_TW;
                    wleft_nx = CNT_W'(2);
                end else if (nwait_q == '0) begin
                    st_nx = ST_T4;
                end else begin
                    st_nx    = ST_TW;
                    wleft_nx = CNT_W'(1);
                end
            end
            ST_TW: begin
                if (wleft <= CNT_W'(1)) begin
                    st_nx    = ST_T4;
                    wleft_nx = '0;
                end else if (wleft == CNT_W'(2)) begin
                    if (rdy_ok) wleft_nx = CNT_W'(1);
                end else begin
                    wleft_nx = wleft - CNT_W'(1);
                end
            end
            ST_T4: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            wleft   <= '0;
            nwait_q <= '0;
            need_q  <= 1'b0;
        end else begin
            st      <= st_nx;
            wleft   <= wleft_nx;
            nwait_q <= nwait_d;
            need_q  <= need_d;
        end
    end

    // Outputs
    always_comb begin
        bus_state = st;
        cyc_done  = (st == ST_T4);
    end

    assert_start_t1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cyc_start) |=> (bus_state == 3'd1));
    assert_t1_t2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == 3'd1) |=> (bus_state == 3'd2));
    assert_t2_t3_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == 3'd2) |=> (bus_state == 3'd3));
    assert_t4_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> (bus_state == 3'd0));
    assert_last_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TW && wleft == CNT_W'(1)) |=> cyc_done);
    assert_zero_noready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_T3 && !need_q && nwait_q == '0) |=> cyc_done);
endmodule

// File: tb/tb_bus_wait_seq.sv
module tb_bus_wait_seq;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 16;
    localparam int  NEVER = 99;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic [2:0] ws_code = '0;
    logic       ws_wide = 1'b0;
    logic       rdy_need = 1'b0;
    logic       pcb_hit = 1'b0;
    logic       ardy_in = 1'b0;
    logic       srdy_in = 1'b0;
    logic [2:0] bus_state;
    logic       cyc_done;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_wait_seq dut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .ws_code(ws_code),
        .ws_wide(ws_wide), .rdy_need(rdy_need), .pcb_hit(pcb_hit),
        .ardy_in(ardy_in), .srdy_in(srdy_in), .bus_state(bus_state),
        .cyc_done(cyc_done)
    );

    // {wide, code, need, pcb, ready_at, expected length}
    typedef struct packed {
        logic       wide;
        logic [2:0] code;
        logic       need;
        logic       pcb;
        logic [7:0] rdy_at;
        logic [7:0] exp_len;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'd0, 1'b0, 1'b0, 8'd0,  8'd4},   // R3 R5
        '{1'b0, 3'd3, 1'b0, 1'b0, 8'd0,  8'd7},   // R3
        '{1'b0, 3'd6, 1'b0, 1'b0, 8'd0,  8'd6},   // R3 bit2 ignored
        '{1'b1, 3'd4, 1'b0, 1'b0, 8'd0,  8'd9},   // R4
        '{1'b1, 3'd5, 1'b0, 1'b0, 8'd0,  8'd11},  // R4
        '{1'b1, 3'd6, 1'b0, 1'b0, 8'd0,  8'd13},  // R4
        '{1'b1, 3'd7, 1'b0, 1'b0, 8'd0,  8'd19},  // R4
        '{1'b1, 3'd2, 1'b1, 1'b0, 8'd0,  8'd6},   // R7
        '{1'b1, 3'd7, 1'b1, 1'b1, 8'd99, 8'd4},   // R6
        '{1'b0, 3'd2, 1'b1, 1'b0, 8'd6,  8'd8},   // R8
        '{1'b0, 3'd0, 1'b1, 1'b0, 8'd5,  8'd7},   // R8
        '{1'b0, 3'd1, 1'b1, 1'b0, 8'd3,  8'd5},   // R7
        '{1'b0, 3'd1, 1'b1, 1'b0, 8'd4,  8'd6},   // R8
        '{1'b1, 3'd5, 1'b1, 1'b0, 8'd9,  8'd11},  // R7
        '{1'b1, 3'd5, 1'b1, 1'b0, 8'd10, 8'd12},  // R8
        '{1'b0, 3'd2, 1'b0, 1'b0, 8'd99, 8'd6}    // R5 ready ignored
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one cycle; ready line chosen by use_async, held high from clock rdy_at on.
    task automatic run_cycle(input bit wide, input bit [2:0] code, input bit need,
                             input bit pcb, input int rdy_at, input bit use_async,
                             input bit poke, input int exp_len, input string req);
        int  len = 0;
        bit  seq_ok = 1'b1;
        bit  done_ok = 1'b1;
        srdy_in = 1'b0;
        ardy_in = 1'b0;
        if (use_async && rdy_at == 0) begin
            ardy_in = 1'b1;
            repeat (3) @(negedge clk);
        end
        if (!use_async) srdy_in = (rdy_at == 0);
        ws_wide = wide; ws_code = code; rdy_need = need; pcb_hit = pcb;
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        // R11: scramble configuration after capture
        ws_wide = ~wide; ws_code = ~code; rdy_need = ~need; pcb_hit = ~pcb;
        for (int idx = 1; idx <= 40; idx++) begin
            if (use_async) ardy_in = (idx >= rdy_at);
            else           srdy_in = (idx >= rdy_at);
            if (poke && idx == 2) cyc_start = 1'b1;
            if (poke && idx == 3) cyc_start = 1'b0;
            if (idx == 1 && bus_state != 3'd1) seq_ok = 1'b0;
            if (idx == 2 && bus_state != 3'd2) seq_ok = 1'b0;
            if (idx == 3 && bus_state != 3'd3) seq_ok = 1'b0;
            if (idx > 3 && bus_state != 3'd4 && bus_state != 3'd5) seq_ok = 1'b0;
            if (cyc_done != (bus_state == 3'd5)) done_ok = 1'b0;
            if (bus_state == 3'd5 || bus_state == 3'd0) begin
                len = idx;
                break;
            end
            @(negedge clk);
        end
        check(len == exp_len, req, len, exp_len);
        check(seq_ok, "R2 state order", seq_ok, 1);
        check(done_ok && cyc_done, "R10 done in T4", cyc_done, 1);
        srdy_in = 1'b0; ardy_in = 1'b0; cyc_start = 1'b0;
        @(negedge clk);
        check(bus_state == 3'd0 && !cyc_done, "R2 back to IDLE", bus_state, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check(bus_state == 3'd0, "R1 reset state", bus_state, 0);
        check(cyc_done == 1'b0, "R1 reset done", cyc_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_state == 3'd0, "R1 idle after reset", bus_state, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_cycle(VECS[i].wide, VECS[i].code, VECS[i].need, VECS[i].pcb,
                      int'(VECS[i].rdy_at), 1'b0, 1'b0, int'(VECS[i].exp_len),
                      $sformatf("R3 R4 R5 R6 R7 R8 vec%0d", i));
        end

        // R9: async ready held high before the cycle behaves like sync ready
        run_cycle(1'b0, 3'd2, 1'b1, 1'b0, 0, 1'b1, 1'b0, 6, "R9 async early");
        // R9: ardy raised in clock 3 counts from clock 5 -> T4 in clock 7
        run_cycle(1'b0, 3'd2, 1'b1, 1'b0, 3, 1'b1, 1'b0, 7, "R9 async latency");
        // R9: ardy raised in clock 2 counts in clock 4 (sampling point) -> 6
        run_cycle(1'b0, 3'd2, 1'b1, 1'b0, 2, 1'b1, 1'b0, 6, "R9 async on time");
        // R11: start pulse mid-cycle ignored, three waits -> 7
        run_cycle(1'b0, 3'd3, 1'b0, 1'b0, 0, 1'b0, 1'b1, 7, "R11 start ignored");

        // R1: reset in mid-cycle returns to IDLE
        ws_wide = 1'b1; ws_code = 3'd7; rdy_need = 1'b0; pcb_hit = 1'b0;
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(bus_state == 3'd0 && !cyc_done, "R1 reset mid-cycle", bus_state, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule